// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data wires of a keyboard-to-host PS/2 link, both asynchronous to the fast system clock, and turns them into scan-code events. Each 11-bit frame is rebuilt bit by bit on falling edges of the keyboard clock. The frame is accepted only when its first bit is low, its last bit is high and the data byte together with the parity bit holds an odd number of ones.

An accepted byte of 0xF0 is a release prefix and is never reported. The next accepted byte is reported with the release flag set, and the prefix is then cleared. Any other accepted byte is reported as a press. A frame that fails any check produces a one-cycle error pulse and is discarded. If the keyboard clock stops in the middle of a frame for longer than a set timeout, the receiver returns to waiting for a start bit.

Top module: `ps2_kbd_rx`

## Requirements
- R1: After the active-low reset is released, `key_code_o`, `key_rel_o`, `key_vld_o` and `frame_err_o` are all 0.
- R2: Each bit is sampled on a falling edge of `kbd_clk_i`, in this order: start bit, data bits 0 to 7 (least significant bit first), parity bit, stop bit. A valid frame whose byte is not 0xF0, with no release prefix pending, drives `key_code_o` to that byte and `key_rel_o` to 0, and pulses `key_vld_o` for one cycle.
- R3: A frame is rejected when the data byte plus the parity bit hold an even number of ones. The parity bit must be 1 when the byte has an even number of ones and 0 when it has an odd number.
- R4: A frame whose start bit is 1 is rejected.
- R5: A frame whose stop bit is 0 is rejected.
- R6: A valid 0xF0 byte is never reported and sets the release prefix. The next valid non-0xF0 byte is reported with `key_rel_o` = 1, and the prefix is then cleared. A second 0xF0 received while the prefix is pending keeps it pending.
- R7: A rejected frame pulses `frame_err_o` for one cycle, produces no `key_vld_o` and leaves the release prefix unchanged.
- R8: If a frame is in progress and no falling edge of `kbd_clk_i` arrives for `TIMEOUT_CYC` system cycles, the partial frame is dropped with no output and the next falling edge is taken as a start bit. A gap shorter than this does not disturb the frame.
- R9: `key_vld_o` and `frame_err_o` are never high in the same cycle, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (nominally 50 MHz) |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| kbd_clk_i | input | 1 | Keyboard clock wire, asynchronous |
| kbd_dat_i | input | 1 | Keyboard data wire, asynchronous |
| key_code_o | output | 8 | Last reported scan-code byte |
| key_rel_o | output | 1 | 1 if the reported byte followed a 0xF0 prefix |
| key_vld_o | output | 1 | One-cycle strobe for a new reported byte |
| frame_err_o | output | 1 | One-cycle strobe for a rejected frame |

## Verification
Two functions compete for the same cycle: the timeout that drops a partial frame, and a keyboard clock edge that moves the bit counter forward. The bench provokes this with a mid-frame gap just below the timeout, where the frame must still decode, and with an idle gap well above it, where the partial bits must be dropped and the next full frame must decode cleanly. A scoreboard also tracks the release prefix across rejected frames, to confirm that an error arriving between 0xF0 and the key byte does not consume the prefix.

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx #(
  parameter int TIMEOUT_CYC = 5000
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  output logic [7:0] key_code_o,
  output logic       key_rel_o,
  output logic       key_vld_o,
  output logic       frame_err_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [3:0] LAST = 4'd10;

  logic [2:0]    kc_q;
  logic [1:0]    kd_q;
  logic [3:0]    bit_cnt;
  logic [9:0]    shf;
  logic [TW-1:0] idle_cnt;
  logic          rel_pend;

  wire fall    = kc_q[2] & ~kc_q[1];
  wire din     = kd_q[1];
  wire tmo_hit = (bit_cnt != 4'd0) && !fall && (idle_cnt == TW'(TIMEOUT_CYC - 1));
  wire stop_ev = fall && (bit_cnt == LAST);
  wire [7:0] byte_w = shf[8:1];
  wire frame_ok = ~shf[0] & din & (^shf[9:1]);

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i) begin
      kc_q <= 3'b111;
      kd_q <= 2'b11;
    end else begin
      kc_q <= {kc_q[1:0], kbd_clk_i};
      kd_q <= {kd_q[0], kbd_dat_i};
    end

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i) begin
      bit_cnt  <= '0;
      shf      <= '0;
      idle_cnt <= '0;
    end else begin
      if (fall || bit_cnt == 4'd0 || tmo_hit) idle_cnt <= '0;
      else                                   idle_cnt <= idle_cnt + 1'b1;
      if (fall) begin
        if (bit_cnt == LAST) bit_cnt <= '0;
        else begin
          bit_cnt <= bit_cnt + 1'b1;
          shf     <= {din, shf[9:1]};
        end
      end else if (tmo_hit) bit_cnt <= '0;
    end

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i) begin
      key_code_o  <= '0;
      key_rel_o   <= 1'b0;
      key_vld_o   <= 1'b0;
      frame_err_o <= 1'b0;
      rel_pend    <= 1'b0;
    end else begin
      key_vld_o   <= 1'b0;
      frame_err_o <= 1'b0;
      if (stop_ev) begin
        if (!frame_ok) frame_err_o <= 1'b1;
        else if (byte_w == 8'hF0) rel_pend <= 1'b1;
        else begin
          key_code_o <= byte_w;
          key_rel_o  <= rel_pend;
          key_vld_o  <= 1'b1;
          rel_pend   <= 1'b0;
        end
      end
    end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bit_cnt <= LAST);                                                     // R2
  AST_NO_F0_OUT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    key_vld_o |-> key_code_o != 8'hF0);                                   // R6
  AST_PREFIX_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    key_vld_o |-> !rel_pend);                                             // R6
  AST_ERR_KEEPS_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_err_o |-> $stable(rel_pend));                                   // R7
  AST_TIMEOUT_DROP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tmo_hit |=> (bit_cnt == 4'd0) && !key_vld_o && !frame_err_o);         // R8
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(key_vld_o && frame_err_o));                                         // R9
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    key_vld_o |=> !key_vld_o);                                            // R9
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_err_o |=> !frame_err_o);                                        // R9
endmodule

// File: tb/ps2_kbd_rx_tb_top.sv
`timescale 1ns/1ps
module ps2_kbd_rx_tb_top;
  localparam int TMO  = 600;
  localparam int HALF = 100;

  typedef struct {
    bit       is_err;
    bit [7:0] code;
    bit       rel;
    string    req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, kclk = 1'b1, kdat = 1'b1;
  logic [7:0] code;
  logic rel, vld, err;
  int n_chk = 0, n_fail = 0;
  bit pend = 1'b0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  ps2_kbd_rx #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .kbd_clk_i(kclk), .kbd_dat_i(kdat),
    .key_code_o(code), .key_rel_o(rel), .key_vld_o(vld), .frame_err_o(err));

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input bit b, input int extra);
    kdat = b;
    wait_cyc(HALF + extra);
    kclk = 1'b0;
    wait_cyc(HALF);
    kclk = 1'b1;
  endtask

  // gap_at: bit index before which the clock stays high for gap_len extra cycles
  task automatic send_frame(input bit [7:0] b, input bit flip_par, input bit bad_start,
                            input bit bad_stop, input int gap_at, input int gap_len,
                            input string req);
    bit [10:0] f;
    exp_t e;
    f = {~bad_stop, (~^b) ^ flip_par, b, bad_start};
    if (bad_start || bad_stop || flip_par) begin
      e = '{1'b1, 8'h00, 1'b0, req};
      q.push_back(e);
    end else if (b == 8'hF0) pend = 1'b1;
    else begin
      e = '{1'b0, b, pend, req};
      q.push_back(e);
      pend = 1'b0;
    end
    for (int i = 0; i < 11; i++) send_bit(f[i], (i == gap_at) ? gap_len : 0);
    wait_cyc(2 * HALF);
  endtask

  bit vld_d = 1'b0, err_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vld && err) chk(1'b0, "R9", "valid and error high together (act 1/1, exp not both)");
      if ((vld && vld_d) || (err && err_d))
        chk(1'b0, "R9", $sformatf("strobe held two cycles (act vld=%0b err=%0b, exp single)", vld, err));
      if (vld || err) begin
        if (q.size() == 0)
          chk(1'b0, "R8", $sformatf("unexpected event vld=%0b err=%0b code=%02h (exp none)", vld, err, code));
        else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_err)
            chk(err && !vld, e.req, $sformatf("act vld=%0b err=%0b, exp error strobe", vld, err));
          else
            chk(vld && code == e.code && rel == e.rel, e.req,
                $sformatf("act vld=%0b code=%02h rel=%0b, exp code=%02h rel=%0b",
                          vld, code, rel, e.code, e.rel));
        end
      end
      vld_d <= vld;
      err_d <= err;
    end
  end

  initial begin
    fork
      begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        chk(code == 8'h00 && !rel && !vld && !err, "R1",
            $sformatf("after reset act code=%02h rel=%0b vld=%0b err=%0b, exp all 0", code, rel, vld, err));
        send_frame(8'h1C, 0, 0, 0, -1, 0, "R2");
        send_frame(8'h15, 0, 0, 0, -1, 0, "R2");
        send_frame(8'hFF, 0, 0, 0, -1, 0, "R2");
        send_frame(8'h00, 0, 0, 0, -1, 0, "R2");
        send_frame(8'hF0, 0, 0, 0, -1, 0, "R6");
        send_frame(8'h1C, 0, 0, 0, -1, 0, "R6");
        send_frame(8'h23, 0, 0, 0, -1, 0, "R6");
        send_frame(8'h24, 1, 0, 0, -1, 0, "R3");
        send_frame(8'h07, 1, 0, 0, -1, 0, "R3");
        send_frame(8'h2C, 0, 1, 0, -1, 0, "R4");
        send_frame(8'h35, 0, 0, 1, -1, 0, "R5");
        send_frame(8'hF0, 0, 0, 0, -1, 0, "R7");
        send_frame(8'h2D, 1, 0, 0, -1, 0, "R7");
        send_frame(8'h2D, 0, 0, 0, -1, 0, "R7");
        send_frame(8'hF0, 0, 0, 0, -1, 0, "R6");
        send_frame(8'hF0, 0, 0, 0, -1, 0, "R6");
        send_frame(8'h1A, 0, 0, 0, -1, 0, "R6");
        // R8: four stray bits, then silence well beyond the timeout
        for (int i = 0; i < 4; i++) send_bit(1'b0, 0);
        wait_cyc(3 * TMO);
        send_frame(8'h4D, 0, 0, 0, -1, 0, "R8");
        // R8: gap below the timeout inside a frame
        send_frame(8'h3A, 0, 0, 0, 5, TMO - 2 * HALF - 50, "R8");
        wait_cyc(50);
        chk(q.size() == 0, "R8", $sformatf("pending expected events act %0d, exp 0", q.size()));
      end
      begin
        wait_cyc(150000);
        chk(1'b0, "R9", "watchdog expired (act hung, exp finish)");
      end
    join_any
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule